// File: doc/BRIEF.md
# Scaled-Index Store Address and Data Unit

This unit is the execute step for a family of indexed stores whose index operand is scaled before it is added. It takes a decoded store operation and three register values: the source data, the base and the index. It forms the effective address as the base plus the index shifted left by one more than a small shift field. It then produces one memory write request. The request carries the address, eight byte lanes of data and a byte-enable mask. The lanes are ordered so that lane k targets address EA+k.

The operation selects a store size of 1, 2, 4 or 8 bytes, a normal or byte-reversed layout, and a plain or update form. The update form writes the computed address back into the base register. An update form whose base field names register zero is an invalid form. The unit flags it and suppresses both the memory write and the writeback. The unit alters no status register. All outputs are registered and appear exactly one cycle after the input valid.

Top module: `sstore_unit`

## Requirements
- R1: The request address memWrAddr equals base + (rbVal << (shAmt+1)) modulo 2^64. shAmt is 2 bits, so the scale is a left shift of 1, 2, 3 or 4.
- R2: For a plain form (opUpdate=0), the base is zero when raFieldZero=1. Otherwise the base is raVal.
- R3: For an update form (opUpdate=1) with raFieldZero=0, the base is raVal. raWbValid is asserted and raWbData equals the request address.
- R4: An update form with raFieldZero=1 asserts invalidForm. It leaves memWrValid and raWbValid low.
- R5: opSize encodes the byte count N: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. memWrMask has exactly its low N bits set. Data lanes at N and above are zero.
- R6: With opReverse=0, the lane memWrData[8k+7:8k] holds byte N-1-k of the low N bytes of rsVal. The most significant byte therefore lands at EA.
- R7: With opReverse=1, lane k holds byte k of rsVal, so the least significant byte lands at EA. A reversed 1-byte store equals a normal one.
- R8: memWrValid, raWbValid and invalidForm reflect the operation accepted at the previous rising edge. All three are low in a cycle that follows an edge where inValid was low.
- R9: A synchronous reset clears memWrValid, raWbValid and invalidForm, even if inValid is high at that edge.
- R10: A plain form never asserts raWbValid or invalidForm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A decoded operation is presented this cycle |
| opSize | input | 2 | Store size code (0:1, 1:2, 2:4, 3:8 bytes) |
| opReverse | input | 1 | Byte-reversed layout |
| opUpdate | input | 1 | Update form (write the address back to the base) |
| rsVal | input | 64 | Source data register value |
| raVal | input | 64 | Base register value |
| rbVal | input | 64 | Index register value |
| raFieldZero | input | 1 | The base register field is zero |
| shAmt | input | 2 | Shift field; the index shift is shAmt+1 |
| memWrValid | output | 1 | Memory write request valid |
| memWrAddr | output | 64 | Effective address |
| memWrData | output | 64 | Byte lanes; lane k targets EA+k |
| memWrMask | output | 8 | Byte enable per lane |
| raWbValid | output | 1 | Base register writeback valid |
| raWbData | output | 64 | Writeback value (the effective address) |
| invalidForm | output | 1 | Invalid instruction form detected |

## Verification
Every result is due at the edge after the one that samples inValid: the write request, the writeback and the invalid flag. The bench drives an operation on a falling edge and drops inValid on the next falling edge. It checks all outputs there, half a cycle after the registering edge. At the start of the following operation, one falling edge later, it checks that the valid flags have returned low. The sweep covers every size, layout, form, zero-field setting and shift value with several data patterns, including a base near the top of the address space so the address add wraps.

// File: rtl/sstore_pkg.sv
package sstore_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE   = 2'd0,
    SZ_HALF   = 2'd1,
    SZ_WORD   = 2'd2,
    SZ_DOUBLE = 2'd3
  } storeSize_e;

  typedef struct packed {
    logic capture;
    logic doWrite;
    logic doWb;
    logic badForm;
  } ctrlStrobe_t;
endpackage

// File: rtl/sstore_ctrl.sv
module sstore_ctrl
  import sstore_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        opUpdate,
  input  logic        raFieldZero,
  output ctrlStrobe_t strobe,
  output logic        memWrValid,
  output logic        raWbValid,
  output logic        invalidForm
);
  always_comb begin
    strobe.capture = inValid;
    strobe.badForm = inValid && opUpdate && raFieldZero;
    strobe.doWrite = inValid && !strobe.badForm;
    strobe.doWb    = strobe.doWrite && opUpdate;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      memWrValid  <= 1'b0;
      raWbValid   <= 1'b0;
      invalidForm <= 1'b0;
    end else begin
      memWrValid  <= strobe.doWrite;
      raWbValid   <= strobe.doWb;
      invalidForm <= strobe.badForm;
    end
  end
endmodule

// File: rtl/sstore_dpath.sv
module sstore_dpath
  import sstore_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SH_W   = 2
) (
  input  logic                clk,
  input  ctrlStrobe_t         strobe,
  input  storeSize_e          opSize,
  input  logic                opReverse,
  input  logic                opUpdate,
  input  logic                raFieldZero,
  input  logic [DATA_W-1:0]   rsVal,
  input  logic [DATA_W-1:0]   raVal,
  input  logic [DATA_W-1:0]   rbVal,
  input  logic [SH_W-1:0]     shAmt,
  output logic [DATA_W-1:0]   memWrAddr,
  output logic [DATA_W-1:0]   memWrData,
  output logic [DATA_W/8-1:0] memWrMask,
  output logic [DATA_W-1:0]   raWbData
);
  localparam int LANES = DATA_W / 8;
  localparam int SHF_W = SH_W + 1;

  logic [DATA_W-1:0] baseSel;
  logic [DATA_W-1:0] scaledIdx;
  logic [DATA_W-1:0] effAddr;
  logic [SHF_W-1:0]  shiftBy;
  logic [DATA_W-1:0] laneData;
  logic [LANES-1:0]  laneEn;
  int                nBytes;

  always_comb begin
    baseSel   = (opUpdate || !raFieldZero) ? raVal : '0;
    shiftBy   = {1'b0, shAmt} + SHF_W'(1);
    scaledIdx = rbVal << shiftBy;
    effAddr   = baseSel + scaledIdx;
    nBytes    = 1 << opSize;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    int srcIdx;
    always_comb begin
      srcIdx = opReverse ? k : (nBytes - 1 - k);
      if (k < nBytes) begin
        laneData[8*k +: 8] = rsVal[8*srcIdx +: 8];
        laneEn[k]          = 1'b1;
      end else begin
        laneData[8*k +: 8] = 8'h00;
        laneEn[k]          = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.capture) begin
      memWrAddr <= effAddr;
      memWrData <= laneData;
      memWrMask <= laneEn;
      raWbData  <= effAddr;
    end
  end
endmodule

// File: rtl/sstore_unit.sv
module sstore_unit
  import sstore_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SH_W   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic [1:0]          opSize,
  input  logic                opReverse,
  input  logic                opUpdate,
  input  logic [DATA_W-1:0]   rsVal,
  input  logic [DATA_W-1:0]   raVal,
  input  logic [DATA_W-1:0]   rbVal,
  input  logic                raFieldZero,
  input  logic [SH_W-1:0]     shAmt,
  output logic                memWrValid,
  output logic [DATA_W-1:0]   memWrAddr,
  output logic [DATA_W-1:0]   memWrData,
  output logic [DATA_W/8-1:0] memWrMask,
  output logic                raWbValid,
  output logic [DATA_W-1:0]   raWbData,
  output logic                invalidForm
);
  ctrlStrobe_t strobe;

  sstore_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .inValid     (inValid),
    .opUpdate    (opUpdate),
    .raFieldZero (raFieldZero),
    .strobe      (strobe),
    .memWrValid  (memWrValid),
    .raWbValid   (raWbValid),
    .invalidForm (invalidForm)
  );

  sstore_dpath #(.DATA_W(DATA_W), .SH_W(SH_W)) u_dpath (
    .clk         (clk),
    .strobe      (strobe),
    .opSize      (storeSize_e'(opSize)),
    .opReverse   (opReverse),
    .opUpdate    (opUpdate),
    .raFieldZero (raFieldZero),
    .rsVal       (rsVal),
    .raVal       (raVal),
    .rbVal       (rbVal),
    .shAmt       (shAmt),
    .memWrAddr   (memWrAddr),
    .memWrData   (memWrData),
    .memWrMask   (memWrMask),
    .raWbData    (raWbData)
  );
endmodule

// File: rtl/sstore_unit_chk.sv
module sstore_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic                clk,
  input logic                rst,
  input logic                inValid,
  input logic                opUpdate,
  input logic                raFieldZero,
  input logic                memWrValid,
  input logic [DATA_W-1:0]   memWrAddr,
  input logic [DATA_W-1:0]   memWrData,
  input logic [DATA_W/8-1:0] memWrMask,
  input logic                raWbValid,
  input logic [DATA_W-1:0]   raWbData,
  input logic                invalidForm
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] maskBits;
  always_comb begin
    for (int k = 0; k < LANES; k++) maskBits[8*k +: 8] = {8{memWrMask[k]}};
  end

  assert_wb_matches_addr_R3: assert property (@(posedge clk) disable iff (rst)
    raWbValid |-> (memWrValid && raWbData == memWrAddr));

  assert_invalid_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    invalidForm |-> (!memWrValid && !raWbValid));

  assert_mask_shape_R5: assert property (@(posedge clk) disable iff (rst)
    memWrValid |-> ((((memWrMask + 1'b1) & memWrMask) == '0) &&
                    ($countones(memWrMask) inside {1, 2, 4, 8})));

  assert_unused_lanes_zero_R5: assert property (@(posedge clk) disable iff (rst)
    memWrValid |-> ((memWrData & ~maskBits) == '0));

  assert_idle_after_no_input_R8: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!memWrValid && !raWbValid && !invalidForm));

  assert_plain_no_wb_R10: assert property (@(posedge clk) disable iff (rst)
    (inValid && !opUpdate) |=> (!raWbValid && !invalidForm));

  assert_bad_form_flagged_R4: assert property (@(posedge clk) disable iff (rst)
    (inValid && opUpdate && raFieldZero) |=> invalidForm);
endmodule

bind sstore_unit sstore_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .inValid     (inValid),
  .opUpdate    (opUpdate),
  .raFieldZero (raFieldZero),
  .memWrValid  (memWrValid),
  .memWrAddr   (memWrAddr),
  .memWrData   (memWrData),
  .memWrMask   (memWrMask),
  .raWbValid   (raWbValid),
  .raWbData    (raWbData),
  .invalidForm (invalidForm)
);

// File: tb/test_sstore_unit.sv
`timescale 1ns/1ps
module test_sstore_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [1:0]  opSize = '0;
  logic        opReverse = 1'b0;
  logic        opUpdate = 1'b0;
  logic [63:0] rsVal = '0;
  logic [63:0] raVal = '0;
  logic [63:0] rbVal = '0;
  logic        raFieldZero = 1'b0;
  logic [1:0]  shAmt = '0;
  logic        memWrValid;
  logic [63:0] memWrAddr;
  logic [63:0] memWrData;
  logic [7:0]  memWrMask;
  logic        raWbValid;
  logic [63:0] raWbData;
  logic        invalidForm;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sstore_unit i_sstore_unit (
    .clk(clk), .rst(rst), .inValid(inValid), .opSize(opSize),
    .opReverse(opReverse), .opUpdate(opUpdate), .rsVal(rsVal),
    .raVal(raVal), .rbVal(rbVal), .raFieldZero(raFieldZero),
    .shAmt(shAmt), .memWrValid(memWrValid), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .memWrMask(memWrMask), .raWbValid(raWbValid),
    .raWbData(raWbData), .invalidForm(invalidForm)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkIdle(input string req);
    check(memWrValid == 1'b0, {req, " memWrValid"}, 64'(memWrValid), 64'd0);
    check(raWbValid == 1'b0, {req, " raWbValid"}, 64'(raWbValid), 64'd0);
    check(invalidForm == 1'b0, {req, " invalidForm"}, 64'(invalidForm), 64'd0);
  endtask

  task automatic runOp(input logic [1:0] sz, input bit rev, input bit upd,
                       input bit raz, input logic [1:0] sh,
                       input logic [63:0] rs, input logic [63:0] ra,
                       input logic [63:0] rb);
    int n;
    logic [63:0] base, ea, data;
    logic [7:0]  mask;
    bit expWr, expWb, expBad;
    n      = 1 << sz;
    base   = (upd || !raz) ? ra : 64'd0;
    ea     = base + (rb << (int'(sh) + 1));
    mask   = 8'((1 << n) - 1);
    data   = '0;
    for (int k = 0; k < n; k++) begin
      if (rev) data[8*k +: 8] = rs[8*k +: 8];
      else     data[8*k +: 8] = rs[8*(n-1-k) +: 8];
    end
    expBad = upd && raz;
    expWr  = !expBad;
    expWb  = upd && !raz;

    @(negedge clk);
    checkIdle("R8 idle");
    opSize = sz; opReverse = rev; opUpdate = upd; raFieldZero = raz;
    shAmt = sh; rsVal = rs; raVal = ra; rbVal = rb; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(memWrValid == expWr, "R4/R8 memWrValid", 64'(memWrValid), 64'(expWr));
    check(raWbValid == expWb, "R3/R10 raWbValid", 64'(raWbValid), 64'(expWb));
    check(invalidForm == expBad, "R4/R10 invalidForm", 64'(invalidForm), 64'(expBad));
    if (expWr) begin
      check(memWrAddr == ea, upd ? "R1 R3 address" : "R1 R2 address",
            memWrAddr, ea);
      check(memWrMask == mask, "R5 mask", 64'(memWrMask), 64'(mask));
      check(memWrData == data, rev ? "R7 reversed lanes" : "R6 normal lanes",
            memWrData, data);
    end
    if (expWb) check(raWbData == ea, "R3 writeback", raWbData, ea);
  endtask

  initial begin
    logic [63:0] rsPat [3];
    logic [63:0] raPat [3];
    logic [63:0] rbPat [3];
    rsPat[0] = 64'h0123_4567_89AB_CDEF; raPat[0] = 64'h0000_0000_0001_0000; rbPat[0] = 64'h10;
    rsPat[1] = 64'hF0E1_D2C3_B4A5_9687; raPat[1] = 64'hFFFF_FFFF_FFFF_FFF0; rbPat[1] = 64'h3;
    rsPat[2] = 64'h8000_0000_0000_00FF; raPat[2] = 64'h1234_5678_0000_0001; rbPat[2] = 64'hC000_0000_0000_0001;

    repeat (3) @(negedge clk);
    checkIdle("R9 reset state");
    rst = 1'b0;

    for (int p = 0; p < 3; p++)
      for (int sz = 0; sz < 4; sz++)
        for (int rv = 0; rv < 2; rv++)
          for (int up = 0; up < 2; up++)
            for (int rz = 0; rz < 2; rz++)
              for (int sh = 0; sh < 4; sh++)
                runOp(2'(sz), bit'(rv), bit'(up), bit'(rz), 2'(sh),
                      rsPat[p], raPat[p], rbPat[p]);

    // R9: reset at the same edge as a valid operation clears the flags
    @(negedge clk);
    opUpdate = 1'b1; raFieldZero = 1'b0; inValid = 1'b1; rst = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    checkIdle("R9 reset overrides input");
    rst = 1'b0;
    // R4: invalid update form while back-to-back with a valid one
    runOp(2'd3, 1'b1, 1'b1, 1'b1, 2'd3, 64'hAA, 64'h5, 64'h7);
    runOp(2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 64'h1234, 64'h100, 64'h1);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule